// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block models the security register of a 16-bit flash device, driven by commands. It holds 128 bits split into two 64-bit halves of four 16-bit words each, plus a lock word. The half at 81h–84h is fixed at build time from a parameter and is always locked. The half at 85h–88h belongs to the user. Software writes single command cycles, each with an address and a data word. The controller decodes the low byte of the data as a command. It enters an identification read mode, arms a program operation whose next write cycle carries the target and the data, clears a sticky error flag, or goes back to normal array reads.

Programming only ever clears bits. The stored word becomes the old word ANDed with the data. A lock bit in the lock word at 80h can be cleared once, and after that the user half is frozen. A program aimed at a locked word, or at an address outside 80h–88h, changes nothing and raises the error flag. Reads are combinational. While the controller is in identification mode they return the manufacturer code, the device code, the lock word and the two register halves. In any other mode they return zero.

The state machine has four states:
- `ST_ARRAY`: the reset state, normal array reads.
- `ST_IDENT`: identification reads.
- `ST_PSET_ARR`: a program is armed and the controller was in array mode.
- `ST_PSET_ID`: a program is armed and the controller was in identification mode.

The transitions are:
- C0h goes from `ST_ARRAY` to `ST_PSET_ARR`, and from `ST_IDENT` to `ST_PSET_ID`.
- 90h goes from `ST_ARRAY` or `ST_IDENT` to `ST_IDENT`.
- FFh goes to `ST_ARRAY`.
- 50h leaves the state where it is.
- Any other byte goes to `ST_ARRAY`.
- The data cycle goes from `ST_PSET_ARR` back to `ST_ARRAY`, and from `ST_PSET_ID` back to `ST_IDENT`.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset the controller is in array mode, `id_mode` and `prog_err` are 0, and every user word reads FFFFh. The lock word reads FFFEh: bit 0 (factory lock) is 0 and bit 1 (user lock) is 1.
- R2: A write cycle whose low data byte is 90h enters identification mode. There, address 00000h reads 002Ch. Address 00001h reads 44B4h when `BOTTOM_BOOT` is 0 and 44B5h when it is 1.
- R3: In identification mode, addresses 81h–84h return `FACTORY_ID` one 16-bit slice per word, with bits 15:0 at 81h and bits 63:48 at 84h.
- R4: A C0h cycle followed by a data cycle to 85h–88h, with the user half unlocked, makes that word the old value ANDed with the data. No bit ever goes from 0 back to 1.
- R5: A C0h cycle followed by a data cycle to 80h clears lock bit 1 when data bit 1 is 0. The lock word then reads FFFCh. Bit 1 never returns to 1, and a program to 80h never raises the error flag.
- R6: Once lock bit 1 is 0, a program to 85h–88h leaves the user words unchanged and sets `prog_err`.
- R7: A program to 81h–84h, or to any address other than 80h–88h, changes no storage and sets `prog_err`.
- R8: `prog_err` stays set until a cycle with command 50h clears it. 50h does not change the mode.
- R9: FFh returns to array mode, and any unrecognised command byte does the same. Outside identification mode every read returns 0000h.
- R10: The write cycle after C0h is always taken as program data, never as a command. It then returns to the mode that was active before C0h.
- R11: Reads are combinational. In the cycle that carries a program's data, a read of the target returns the old word, and from the next cycle it returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write cycle strobe, one cycle per command or data word |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 16 | Write cycle data; the low byte is the command |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read data: identification data, or 0 outside identification mode |
| id_mode | output | 1 | High while identification reads are enabled |
| prog_err | output | 1 | Sticky program error flag |

## Verification
Two functions can fall in the same cycle: a program data cycle that updates a user word, and a combinational read of that same word. The bench first arms a program from identification mode. It then drives the data cycle to word 85h with `rd_addr` pointing at 85h. Before the edge it expects the erased value FFFFh. After the edge it expects the ANDed value, with `id_mode` still high because the controller has returned to identification mode. A table of vectors also mixes failing programs, error clears and mode changes, so the error flag and the mode are each judged across the cycles that touch the other.

// File: rtl/otp_prot_pkg.sv
package otp_prot_pkg;

    localparam int WORD_W = 16;

    // Command bytes (low data byte of a write cycle)
    localparam logic [7:0] CMD_PSETUP = 8'hC0;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_CLRERR = 8'h50;

    // Identification words
    localparam logic [WORD_W-1:0] MANUF_CODE = 16'h002C;
    localparam logic [WORD_W-1:0] DEV_TOP    = 16'h44B4;
    localparam logic [WORD_W-1:0] DEV_BOT    = 16'h44B5;

    // Factory lock bit: permanently programmed (0)
    localparam logic FACT_LOCK_N = 1'b0;

    typedef enum logic [1:0] {
        ST_ARRAY,
        ST_IDENT,
        ST_PSET_ARR,
        ST_PSET_ID
    } otp_state_e;

    typedef enum logic [1:0] {
        RGN_LOCK,
        RGN_FACT,
        RGN_USER,
        RGN_NONE
    } otp_region_e;

    // Word index inside a half: 81h/85h -> 0 ... 84h/88h -> 3
    function automatic logic [1:0] word_idx(input logic [31:0] a);
        return a[1:0] - 2'd1;
    endfunction

    function automatic otp_region_e region_of(input logic [31:0] a);
        if (a == 32'h80)
            return RGN_LOCK;
        else if (a >= 32'h81 && a <= 32'h84)
            return RGN_FACT;
        else if (a >= 32'h85 && a <= 32'h88)
            return RGN_USER;
        else
            return RGN_NONE;
    endfunction

endpackage

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output otp_state_e        state,
    output logic              pgm_fire,
    output logic              clr_err,
    output logic              id_mode
);

    otp_state_e state_nxt;
    logic [7:0] cmd;
    logic       cmd_known;

    assign cmd       = wr_data[7:0];
    assign cmd_known = (cmd == CMD_PSETUP) || (cmd == CMD_IDENT) ||
                       (cmd == CMD_ARRAY)  || (cmd == CMD_CLRERR);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ARRAY, ST_IDENT: begin
                if (wr_en) begin
                    case (cmd)
                        CMD_PSETUP: state_nxt = (state == ST_IDENT) ? ST_PSET_ID : ST_PSET_ARR;
                        CMD_IDENT:  state_nxt = ST_IDENT;
                        CMD_ARRAY:  state_nxt = ST_ARRAY;
                        CMD_CLRERR: state_nxt = state;
                        default:    state_nxt = ST_ARRAY;
                    endcase
                end
            end
            ST_PSET_ARR: if (wr_en) state_nxt = ST_ARRAY;
            ST_PSET_ID:  if (wr_en) state_nxt = ST_IDENT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_ARRAY;
        else
            state <= state_nxt;
    end

    // Outputs
    always_comb begin
        pgm_fire = 1'b0;
        clr_err  = 1'b0;
        id_mode  = 1'b0;
        unique case (state)
            ST_ARRAY:    clr_err  = wr_en && (cmd == CMD_CLRERR);
            ST_IDENT: begin
                clr_err = wr_en && (cmd == CMD_CLRERR);
                id_mode = 1'b1;
            end
            ST_PSET_ARR: pgm_fire = wr_en;
            ST_PSET_ID: begin
                pgm_fire = wr_en;
                id_mode  = 1'b1;
            end
        endcase
    end

    // R10: the data cycle returns to the mode that preceded the setup command
    p_data_to_ident_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_PSET_ID) |=> (state == ST_IDENT));
    p_data_to_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_PSET_ARR) |=> (state == ST_ARRAY));

    // R9: an unrecognised command byte drops back to array mode
    p_unknown_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cmd_known && (state == ST_ARRAY || state == ST_IDENT))
        |=> (state == ST_ARRAY));

endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_prot_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NWORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pgm_fire,
    input  logic [ADDR_W-1:0]            pgm_addr,
    input  logic [WORD_W-1:0]            pgm_data,
    input  logic                         clr_err,
    output logic [NWORDS-1:0][WORD_W-1:0] user_words,
    output logic                         user_unlk,
    output logic                         prog_err
);

    otp_region_e region;
    logic [1:0]  idx;
    logic        bad_req;
    logic        user_ok;

    assign region  = region_of(32'(pgm_addr));
    assign idx     = word_idx(32'(pgm_addr));
    assign user_ok = pgm_fire && (region == RGN_USER) && user_unlk;

    // The factory half is always locked (its lock bit is permanently 0)
    always_comb begin
        bad_req = 1'b0;
        if (pgm_fire) begin
            unique case (region)
                RGN_LOCK: bad_req = 1'b0;
                RGN_FACT: bad_req = (FACT_LOCK_N == 1'b0);
                RGN_USER: bad_req = !user_unlk;
                RGN_NONE: bad_req = 1'b1;
            endcase
        end
    end

    // User lock bit: can only be cleared
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            user_unlk <= 1'b1;
        else if (pgm_fire && region == RGN_LOCK)
            user_unlk <= user_unlk & pgm_data[1];
    end

    // Sticky error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prog_err <= 1'b0;
        else if (bad_req)
            prog_err <= 1'b1;
        else if (clr_err)
            prog_err <= 1'b0;
    end

    // One-way programmable user words
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                user_words[i] <= '1;
            else if (user_ok && idx == 2'(i))
                user_words[i] <= user_words[i] & pgm_data;
        end
    end

    // R4: no stored bit ever rises
    p_one_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((user_words & ~$past(user_words)) == '0));

    // R5: once cleared, the user lock stays cleared
    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !user_unlk |=> !user_unlk);

    // R6: a program into a locked user half changes nothing and flags an error
    p_locked_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_fire && region == RGN_USER && !user_unlk)
        |=> ($stable(user_words) && prog_err));

    // R7: out-of-range or factory targets flag an error
    p_bad_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_fire && (region == RGN_NONE || region == RGN_FACT))
        |=> ($stable(user_words) && prog_err));

    // R8: the error flag holds until cleared
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !clr_err) |=> prog_err);

endmodule

// File: rtl/otp_read_mux.sv
module otp_read_mux
    import otp_prot_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter int          NWORDS      = 4,
    parameter logic [63:0] FACTORY_ID  = 64'h0123_4567_89AB_CDEF,
    parameter bit          BOTTOM_BOOT = 1'b0
) (
    input  logic                          id_mode,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NWORDS-1:0][WORD_W-1:0] user_words,
    input  logic                          user_unlk,
    output logic [WORD_W-1:0]             rd_data
);

    logic [NWORDS-1:0][WORD_W-1:0] fact_words;
    logic [WORD_W-1:0]             dev_code;
    logic [WORD_W-1:0]             lock_word;
    logic [31:0]                   a;

    assign fact_words = FACTORY_ID;
    assign lock_word  = {{(WORD_W-2){1'b1}}, user_unlk, FACT_LOCK_N};
    assign a          = 32'(rd_addr);

    if (BOTTOM_BOOT) begin : g_bot
        assign dev_code = DEV_BOT;
    end else begin : g_top
        assign dev_code = DEV_TOP;
    end

    always_comb begin
        rd_data = '0;
        if (id_mode) begin
            if (a == 32'h0)
                rd_data = MANUF_CODE;
            else if (a == 32'h1)
                rd_data = dev_code;
            else begin
                unique case (region_of(a))
                    RGN_LOCK: rd_data = lock_word;
                    RGN_FACT: rd_data = fact_words[word_idx(a)];
                    RGN_USER: rd_data = user_words[word_idx(a)];
                    RGN_NONE: rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg
    import otp_prot_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter logic [63:0] FACTORY_ID  = 64'h0123_4567_89AB_CDEF,
    parameter bit          BOTTOM_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              id_mode,
    output logic              prog_err
);

    localparam int NWORDS = 64 / WORD_W;

    otp_state_e                    state;
    logic                          pgm_fire;
    logic                          clr_err;
    logic [NWORDS-1:0][WORD_W-1:0] user_words;
    logic                          user_unlk;

    otp_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .state    (state),
        .pgm_fire (pgm_fire),
        .clr_err  (clr_err),
        .id_mode  (id_mode)
    );

    otp_store #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgm_fire   (pgm_fire),
        .pgm_addr   (wr_addr),
        .pgm_data   (wr_data),
        .clr_err    (clr_err),
        .user_words (user_words),
        .user_unlk  (user_unlk),
        .prog_err   (prog_err)
    );

    otp_read_mux #(
        .ADDR_W      (ADDR_W),
        .NWORDS      (NWORDS),
        .FACTORY_ID  (FACTORY_ID),
        .BOTTOM_BOOT (BOTTOM_BOOT)
    ) u_rmux (
        .id_mode    (id_mode),
        .rd_addr    (rd_addr),
        .user_words (user_words),
        .user_unlk  (user_unlk),
        .rd_data    (rd_data)
    );

    // R9: nothing is visible outside identification mode
    p_array_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> (rd_data == '0));

    // R2: manufacturer code at address 0 in identification mode
    p_manuf_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_addr == '0) |-> (rd_data == MANUF_CODE));

    // R10: a program data cycle never leaves the mode it started in
    p_data_keeps_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_fire |=> (id_mode == $past(id_mode)));

endmodule

// File: tb/otp_prot_reg_tb.sv
`timescale 1ns/1ps
module otp_prot_reg_tb;

    localparam int OP_W = 0;
    localparam int OP_R = 1;
    localparam int OP_E = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 63;

    // op, addr, data, expected, requirement number
    localparam vec_t TBL [NV] = '{
        '{2'd0, 20'h00000, 16'h0090, 16'h0000, 8'd2},
        '{2'd1, 20'h00000, 16'h0000, 16'h002C, 8'd2},   // R2 manufacturer
        '{2'd1, 20'h00001, 16'h0000, 16'h44B4, 8'd2},   // R2 device code, top boot
        '{2'd1, 20'h00081, 16'h0000, 16'hCDEF, 8'd3},   // R3 low factory word
        '{2'd1, 20'h00084, 16'h0000, 16'h0123, 8'd3},   // R3 high factory word
        '{2'd1, 20'h00080, 16'h0000, 16'hFFFE, 8'd1},   // R1 lock word
        '{2'd1, 20'h00085, 16'h0000, 16'hFFFF, 8'd1},   // R1 erased user word
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd4},
        '{2'd0, 20'h00085, 16'h12F0, 16'h0000, 8'd4},
        '{2'd1, 20'h00085, 16'h0000, 16'h12F0, 8'd4},   // R4 first program
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd4},
        '{2'd0, 20'h00085, 16'hFF0F, 16'h0000, 8'd4},
        '{2'd1, 20'h00085, 16'h0000, 16'h1200, 8'd4},   // R4 AND, no 0->1
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd4},
        '{2'd0, 20'h00088, 16'hA5A5, 16'h0000, 8'd4},
        '{2'd1, 20'h00088, 16'h0000, 16'hA5A5, 8'd4},   // R4 last user word
        '{2'd1, 20'h00086, 16'h0000, 16'hFFFF, 8'd4},   // R4 neighbour untouched
        '{2'd2, 20'h00000, 16'h0000, 16'h0000, 8'd7},   // R7 no error yet
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd7},
        '{2'd0, 20'h00082, 16'h0000, 16'h0000, 8'd7},
        '{2'd2, 20'h00000, 16'h0000, 16'h0001, 8'd7},   // R7 factory write error
        '{2'd1, 20'h00082, 16'h0000, 16'h89AB, 8'd7},   // R7 factory unchanged
        '{2'd0, 20'h00000, 16'h0050, 16'h0000, 8'd8},
        '{2'd2, 20'h00000, 16'h0000, 16'h0000, 8'd8},   // R8 cleared
        '{2'd1, 20'h00000, 16'h0000, 16'h002C, 8'd8},   // R8 mode kept
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd7},
        '{2'd0, 20'h00089, 16'h0000, 16'h0000, 8'd7},
        '{2'd2, 20'h00000, 16'h0000, 16'h0001, 8'd7},   // R7 out of range
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd8},
        '{2'd0, 20'h00085, 16'h0000, 16'h0000, 8'd8},
        '{2'd2, 20'h00000, 16'h0000, 16'h0001, 8'd8},   // R8 good program keeps error
        '{2'd1, 20'h00085, 16'h0000, 16'h0000, 8'd4},   // R4
        '{2'd0, 20'h00000, 16'h0050, 16'h0000, 8'd8},
        '{2'd2, 20'h00000, 16'h0000, 16'h0000, 8'd8},   // R8
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd10},
        '{2'd0, 20'h00000, 16'h00FF, 16'h0000, 8'd10},
        '{2'd1, 20'h00000, 16'h0000, 16'h002C, 8'd10},  // R10 FFh taken as data
        '{2'd2, 20'h00000, 16'h0000, 16'h0001, 8'd10},  // R10 data at 0 is an error
        '{2'd0, 20'h00000, 16'h0050, 16'h0000, 8'd8},
        '{2'd0, 20'h00000, 16'h00FF, 16'h0000, 8'd9},
        '{2'd1, 20'h00000, 16'h0000, 16'h0000, 8'd9},   // R9 array read
        '{2'd1, 20'h00081, 16'h0000, 16'h0000, 8'd9},   // R9 array read
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd9},
        '{2'd0, 20'h00086, 16'hF0F0, 16'h0000, 8'd9},
        '{2'd1, 20'h00086, 16'h0000, 16'h0000, 8'd9},   // R9 back in array mode
        '{2'd0, 20'h00000, 16'h0090, 16'h0000, 8'd4},
        '{2'd1, 20'h00086, 16'h0000, 16'hF0F0, 8'd4},   // R4 program from array mode
        '{2'd0, 20'h00000, 16'h0033, 16'h0000, 8'd9},
        '{2'd1, 20'h00000, 16'h0000, 16'h0000, 8'd9},   // R9 unknown command
        '{2'd0, 20'h00000, 16'h0090, 16'h0000, 8'd5},
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd5},
        '{2'd0, 20'h00080, 16'hFFFD, 16'h0000, 8'd5},
        '{2'd1, 20'h00080, 16'h0000, 16'hFFFC, 8'd5},   // R5 user lock cleared
        '{2'd2, 20'h00000, 16'h0000, 16'h0000, 8'd5},   // R5 no error
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd6},
        '{2'd0, 20'h00087, 16'h0000, 16'h0000, 8'd6},
        '{2'd2, 20'h00000, 16'h0000, 16'h0001, 8'd6},   // R6 locked error
        '{2'd1, 20'h00087, 16'h0000, 16'hFFFF, 8'd6},   // R6 unchanged
        '{2'd0, 20'h00000, 16'h0050, 16'h0000, 8'd5},
        '{2'd0, 20'h00000, 16'h00C0, 16'h0000, 8'd5},
        '{2'd0, 20'h00080, 16'hFFFF, 16'h0000, 8'd5},
        '{2'd1, 20'h00080, 16'h0000, 16'hFFFC, 8'd5},   // R5 lock cannot return
        '{2'd2, 20'h00000, 16'h0000, 16'h0000, 8'd5}    // R5 no error
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [19:0] wr_addr;
    logic [15:0] wr_data;
    logic [19:0] rd_addr;
    logic [15:0] rd_data;
    logic        id_mode;
    logic        prog_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    otp_prot_reg u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .id_mode  (id_mode),
        .prog_err (prog_err)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        do_reset();

        // R1: reset state at the ports
        #1;
        check("R1 rd_data", rd_data, 16'h0000);
        check("R1 id_mode", {15'd0, id_mode}, 16'h0000);
        check("R1 prog_err", {15'd0, prog_err}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", TBL[i].req, i);
            case (int'(TBL[i].op))
                OP_W: do_write(TBL[i].addr, TBL[i].data);
                OP_R: begin
                    rd_addr = TBL[i].addr;
                    #1;
                    check(tag, rd_data, TBL[i].exp);
                end
                OP_E: begin
                    #1;
                    check(tag, {15'd0, prog_err}, TBL[i].exp);
                end
                default: ;
            endcase
        end

        // R1: a fresh reset restores the erased state
        do_reset();
        #1;
        check("R1 err after reset", {15'd0, prog_err}, 16'h0000);
        do_write(20'h00000, 16'h0090);
        rd_addr = 20'h00085;
        #1;
        check("R1 user word", rd_data, 16'hFFFF);
        rd_addr = 20'h00080;
        #1;
        check("R1 lock word", rd_data, 16'hFFFE);

        // R11: program data cycle and read of the same word in one cycle
        do_write(20'h00000, 16'h00C0);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 20'h00085;
        wr_data = 16'h00FF;
        rd_addr = 20'h00085;
        #1;
        check("R11 old value in data cycle", rd_data, 16'hFFFF);
        check("R10 id_mode during setup", {15'd0, id_mode}, 16'h0001);
        @(posedge clk);
        #1;
        check("R11 new value after edge", rd_data, 16'h00FF);
        check("R10 back in ident mode", {15'd0, id_mode}, 16'h0001);
        @(negedge clk);
        wr_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule